// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block works out the state a 32-bit processor core moves into when it takes an exception. Each cycle the pipeline presents its event strobes and interrupt requests. It also presents the current status word, the relevant instruction addresses and a few configuration inputs. The block picks the single most urgent event and produces the entry state for it. That state is the rewritten status word, the status word to be saved, a selector naming the mode that receives the saved copy, the return link address and the handler address.

Interrupts are gated by their mask bits in the current status word. They are only accepted at an instruction boundary. An instruction-fetch abort counts only if the flagged instruction really executes. All results are registered. They appear together with a one-cycle take strobe in the cycle after the inputs are sampled. The core uses them to write its banked registers and redirect fetch.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted, and until the first entry after reset, take is 0 and every other output is 0. The active-low reset is asserted asynchronously and released after two clock edges.
- R2: The selector bank_sel and new_status[4:0] both carry the mode code of the taken exception:
  - reset and software trap: 5'b10011
  - undefined instruction: 5'b11011
  - either abort: 5'b10111
  - normal interrupt: 5'b10010
  - fast interrupt: 5'b10001
- R3: On every entry, new_status bit 5 is 0, bit 7 is 1 and bit 9 equals endian_in. Bits 10 and up are copied from cur_status.
- R4: new_status bit 6 is set to 1 for reset and fast interrupt. For every other exception it is copied from cur_status.
- R5: new_status bit 8 is copied from cur_status for undefined instruction and software trap. For every other exception it is set to 1.
- R6: link_addr is computed modulo 2^32 as follows:
  - undefined and trap: next_addr
  - fetch abort: fault_addr+4
  - data abort: fault_addr+8
  - either interrupt: next_addr+4
  - reset: 0
- R7: saved_status equals cur_status for every exception except reset, which gives 0.
- R8: target_pc is the base plus the offset. The base is 0, or 0xFFFF0000 when hivec is 1. The offsets are reset 0x00, undefined 0x04, trap 0x08, fetch abort 0x0C, data abort 0x10, interrupt 0x18 and fast interrupt 0x1C.
- R9: When vect_en is 1, both interrupts take target_pc from vect_addr. All other exceptions are unaffected.
- R10: A normal interrupt is accepted only when at_boundary is 1 and cur_status bit 7 is 0. A fast interrupt is accepted only when at_boundary is 1 and cur_status bit 6 is 0. A request that is refused produces no take.
- R11: A fetch abort strobe is ignored, with no take, unless exec_valid is 1.
- R12: When several accepted events coincide, exactly one is taken. The order from highest to lowest is reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined instruction, software trap.
- R13: take is 1 for exactly the cycle after an accepted event is sampled, and 0 otherwise. The other outputs keep their last values until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_reset | input | 1 | Reset-style entry request |
| ev_undef | input | 1 | Undefined instruction strobe |
| ev_trap | input | 1 | Software trap instruction strobe |
| ev_pabort | input | 1 | Instruction carries a fetch-abort flag |
| ev_dabort | input | 1 | Data access abort strobe |
| irq_req | input | 1 | Normal interrupt request |
| fast_req | input | 1 | Fast interrupt request |
| at_boundary | input | 1 | Pipeline is at an instruction boundary |
| exec_valid | input | 1 | The flagged instruction reaches execution |
| cur_status | input | STAT_W | Status word before entry |
| fault_addr | input | ADDR_W | Address of the aborted instruction |
| next_addr | input | ADDR_W | Address of the next instruction |
| hivec | input | 1 | Handler table sits at the high base |
| vect_en | input | 1 | Interrupts use vect_addr |
| vect_addr | input | ADDR_W | Externally supplied interrupt handler address |
| endian_in | input | 1 | Endianness bit loaded on entry |
| take | output | 1 | One-cycle entry strobe |
| new_status | output | STAT_W | Status word after entry |
| saved_status | output | STAT_W | Status word to save in the target mode |
| bank_sel | output | 5 | Mode receiving the saved status and link |
| link_addr | output | ADDR_W | Return link value |
| target_pc | output | ADDR_W | Handler address |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 32-bit status word and a high base of 0xFFFF0000. With full-width addresses, fault and next addresses of 0xFFFFFFFC exercise the link offsets wrapping past the top of the address space. The high base is reached with the full upper half set. Two status patterns with different upper bits and with bits 8 and 9 set or clear show which fields are copied and which are forced. Every exception is taken under all four combinations of hivec and vect_en.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EXC_NONE,
    EXC_RESET,
    EXC_UNDEF,
    EXC_TRAP,
    EXC_PABT,
    EXC_DABT,
    EXC_IRQ,
    EXC_FAST
  } exc_kind_e;

  localparam logic [4:0] MODE_SUPV = 5'b10011;
  localparam logic [4:0] MODE_UNDF = 5'b11011;
  localparam logic [4:0] MODE_ABRT = 5'b10111;
  localparam logic [4:0] MODE_IRQ  = 5'b10010;
  localparam logic [4:0] MODE_FAST = 5'b10001;

  localparam int BIT_STATE  = 5;
  localparam int BIT_FMASK  = 6;
  localparam int BIT_IMASK  = 7;
  localparam int BIT_AMASK  = 8;
  localparam int BIT_ENDIAN = 9;

  function automatic logic [4:0] mode_code(input exc_kind_e k);
    case (k)
      EXC_UNDEF:           return MODE_UNDF;
      EXC_PABT, EXC_DABT:  return MODE_ABRT;
      EXC_IRQ:             return MODE_IRQ;
      EXC_FAST:            return MODE_FAST;
      default:             return MODE_SUPV;
    endcase
  endfunction

  function automatic logic [4:0] vec_offset(input exc_kind_e k);
    case (k)
      EXC_UNDEF: return 5'h04;
      EXC_TRAP:  return 5'h08;
      EXC_PABT:  return 5'h0C;
      EXC_DABT:  return 5'h10;
      EXC_IRQ:   return 5'h18;
      EXC_FAST:  return 5'h1C;
      default:   return 5'h00;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      ev_reset,
  input  logic      ev_undef,
  input  logic      ev_trap,
  input  logic      ev_pabort,
  input  logic      ev_dabort,
  input  logic      irq_req,
  input  logic      fast_req,
  input  logic      at_boundary,
  input  logic      exec_valid,
  input  logic      irq_masked,
  input  logic      fast_masked,
  output exc_kind_e kind
);
  localparam int NREQ = 7;

  // index 0 is the most urgent
  function automatic exc_kind_e rank_kind(input int idx);
    case (idx)
      0:       return EXC_RESET;
      1:       return EXC_DABT;
      2:       return EXC_FAST;
      3:       return EXC_IRQ;
      4:       return EXC_PABT;
      5:       return EXC_UNDEF;
      default: return EXC_TRAP;
    endcase
  endfunction

  logic [NREQ-1:0] req;

  always_comb begin
    req[0] = ev_reset;
    req[1] = ev_dabort;
    req[2] = fast_req & at_boundary & ~fast_masked;
    req[3] = irq_req & at_boundary & ~irq_masked;
    req[4] = ev_pabort & exec_valid;
    req[5] = ev_undef;
    req[6] = ev_trap;
  end

  always_comb begin
    kind = EXC_NONE;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) kind = rank_kind(i);
    end
  end

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int ADDR_W = 32
) (
  input  exc_kind_e         kind,
  input  logic [STAT_W-1:0] cur_status,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              endian_in,
  output logic [STAT_W-1:0] nxt_status,
  output logic [STAT_W-1:0] nxt_saved,
  output logic [4:0]        nxt_mode,
  output logic [ADDR_W-1:0] nxt_link
);
  localparam logic [ADDR_W-1:0] STEP4 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP8 = ADDR_W'(8);

  always_comb begin
    nxt_mode               = mode_code(kind);
    nxt_status             = cur_status;
    nxt_status[4:0]        = nxt_mode;
    nxt_status[BIT_STATE]  = 1'b0;
    nxt_status[BIT_IMASK]  = 1'b1;
    nxt_status[BIT_ENDIAN] = endian_in;
    if (kind == EXC_RESET || kind == EXC_FAST) nxt_status[BIT_FMASK] = 1'b1;
    if (kind != EXC_UNDEF && kind != EXC_TRAP) nxt_status[BIT_AMASK] = 1'b1;
  end

  always_comb begin
    nxt_saved = (kind == EXC_RESET) ? '0 : cur_status;
    case (kind)
      EXC_UNDEF, EXC_TRAP: nxt_link = next_addr;
      EXC_PABT:            nxt_link = fault_addr + STEP4;
      EXC_DABT:            nxt_link = fault_addr + STEP8;
      EXC_IRQ, EXC_FAST:   nxt_link = next_addr + STEP4;
      default:             nxt_link = '0;
    endcase
  end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = ADDR_W'(32'hFFFF_0000)
) (
  input  exc_kind_e         kind,
  input  logic              hivec,
  input  logic              vect_en,
  input  logic [ADDR_W-1:0] vect_addr,
  output logic [ADDR_W-1:0] nxt_pc
);
  logic [ADDR_W-1:0] base;
  logic              is_intr;

  always_comb begin
    base    = hivec ? HI_BASE : '0;
    is_intr = (kind == EXC_IRQ) || (kind == EXC_FAST);
    if (vect_en && is_intr) nxt_pc = vect_addr;
    else                    nxt_pc = base + ADDR_W'(vec_offset(kind));
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int                STAT_W  = 32,
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = ADDR_W'(32'hFFFF_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_reset,
  input  logic              ev_undef,
  input  logic              ev_trap,
  input  logic              ev_pabort,
  input  logic              ev_dabort,
  input  logic              irq_req,
  input  logic              fast_req,
  input  logic              at_boundary,
  input  logic              exec_valid,
  input  logic [STAT_W-1:0] cur_status,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              hivec,
  input  logic              vect_en,
  input  logic [ADDR_W-1:0] vect_addr,
  input  logic              endian_in,
  output logic              take,
  output logic [STAT_W-1:0] new_status,
  output logic [STAT_W-1:0] saved_status,
  output logic [4:0]        bank_sel,
  output logic [ADDR_W-1:0] link_addr,
  output logic [ADDR_W-1:0] target_pc
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  exc_kind_e         kind;
  logic [STAT_W-1:0] d_status, d_saved;
  logic [4:0]        d_mode;
  logic [ADDR_W-1:0] d_link, d_pc;
  logic              load;

  exc_arbiter u_arb (
    .ev_reset   (ev_reset),
    .ev_undef   (ev_undef),
    .ev_trap    (ev_trap),
    .ev_pabort  (ev_pabort),
    .ev_dabort  (ev_dabort),
    .irq_req    (irq_req),
    .fast_req   (fast_req),
    .at_boundary(at_boundary),
    .exec_valid (exec_valid),
    .irq_masked (cur_status[BIT_IMASK]),
    .fast_masked(cur_status[BIT_FMASK]),
    .kind       (kind)
  );

  exc_state_calc #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_calc (
    .kind      (kind),
    .cur_status(cur_status),
    .fault_addr(fault_addr),
    .next_addr (next_addr),
    .endian_in (endian_in),
    .nxt_status(d_status),
    .nxt_saved (d_saved),
    .nxt_mode  (d_mode),
    .nxt_link  (d_link)
  );

  exc_vector_sel #(.ADDR_W(ADDR_W), .HI_BASE(HI_BASE)) u_vec (
    .kind     (kind),
    .hivec    (hivec),
    .vect_en  (vect_en),
    .vect_addr(vect_addr),
    .nxt_pc   (d_pc)
  );

  assign load = (kind != EXC_NONE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      take         <= 1'b0;
      new_status   <= '0;
      saved_status <= '0;
      bank_sel     <= '0;
      link_addr    <= '0;
      target_pc    <= '0;
    end else begin
      take <= load;
      if (load) begin
        new_status   <= d_status;
        saved_status <= d_saved;
        bank_sel     <= d_mode;
        link_addr    <= d_link;
        target_pc    <= d_pc;
      end
    end
  end

  // entry always forces state, interrupt mask and endianness fields
  assert_entry_bits_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |-> (!new_status[BIT_STATE] && new_status[BIT_IMASK]
              && new_status[BIT_ENDIAN] == $past(endian_in)));

  assert_fast_masks_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && bank_sel == MODE_FAST) |-> new_status[BIT_FMASK]);

  assert_saved_copy_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && !$past(ev_reset)) |-> saved_status == $past(cur_status));

  assert_fast_gate_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && bank_sel == MODE_FAST) |->
      ($past(fast_req) && $past(at_boundary) && !$past(cur_status[BIT_FMASK])));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && bank_sel == MODE_IRQ) |->
      ($past(irq_req) && $past(at_boundary) && !$past(cur_status[BIT_IMASK])));

  assert_pabt_exec_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && bank_sel == MODE_ABRT && !$past(ev_dabort)) |->
      ($past(ev_pabort) && $past(exec_valid)));

  assert_take_cause_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |-> $past(ev_reset | ev_undef | ev_trap | ev_pabort | ev_dabort
                   | irq_req | fast_req));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_reset, ev_undef, ev_trap, ev_pabort, ev_dabort;
  logic        irq_req, fast_req, at_boundary, exec_valid;
  logic [31:0] cur_status, fault_addr, next_addr, vect_addr;
  logic        hivec, vect_en, endian_in;
  logic        take;
  logic [31:0] new_status, saved_status, link_addr, target_pc;
  logic [4:0]  bank_sel;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;  // 125 MHz

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .ev_reset(ev_reset), .ev_undef(ev_undef), .ev_trap(ev_trap),
    .ev_pabort(ev_pabort), .ev_dabort(ev_dabort),
    .irq_req(irq_req), .fast_req(fast_req),
    .at_boundary(at_boundary), .exec_valid(exec_valid),
    .cur_status(cur_status), .fault_addr(fault_addr), .next_addr(next_addr),
    .hivec(hivec), .vect_en(vect_en), .vect_addr(vect_addr),
    .endian_in(endian_in),
    .take(take), .new_status(new_status), .saved_status(saved_status),
    .bank_sel(bank_sel), .link_addr(link_addr), .target_pc(target_pc)
  );

  // kind codes used by the bench: 0 reset, 1 undef, 2 trap, 3 fetch abort,
  // 4 data abort, 5 interrupt, 6 fast interrupt
  function automatic logic [4:0] exp_mode(input int k);
    case (k)
      1:       return 5'b11011;
      3, 4:    return 5'b10111;
      5:       return 5'b10010;
      6:       return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] exp_status(input int k);
    logic [31:0] s = cur_status;
    s[4:0] = exp_mode(k);
    s[5]   = 1'b0;
    s[7]   = 1'b1;
    s[9]   = endian_in;
    if (k == 0 || k == 6) s[6] = 1'b1;
    if (k != 1 && k != 2) s[8] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] exp_link(input int k);
    case (k)
      1, 2:    return next_addr;
      3:       return fault_addr + 32'd4;
      4:       return fault_addr + 32'd8;
      5, 6:    return next_addr + 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_pc(input int k);
    logic [31:0] off;
    case (k)
      1: off = 32'h04;  2: off = 32'h08;  3: off = 32'h0C;
      4: off = 32'h10;  5: off = 32'h18;  6: off = 32'h1C;
      default: off = 32'h00;
    endcase
    if (vect_en && (k == 5 || k == 6)) return vect_addr;
    return (hivec ? 32'hFFFF_0000 : 32'h0) + off;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    ev_reset = 0; ev_undef = 0; ev_trap = 0; ev_pabort = 0; ev_dabort = 0;
    irq_req = 0; fast_req = 0; at_boundary = 1; exec_valid = 1;
  endtask

  task automatic drive_kind(input int k);
    case (k)
      0: ev_reset  = 1;
      1: ev_undef  = 1;
      2: ev_trap   = 1;
      3: ev_pabort = 1;
      4: ev_dabort = 1;
      5: irq_req   = 1;
      default: fast_req = 1;
    endcase
  endtask

  task automatic set_ctx(input int st, input logic hv, input logic ve);
    cur_status = st[0] ? 32'h5A5A_F33F : 32'hA5A5_0C3F;
    endian_in  = ~st[0];
    fault_addr = st[0] ? 32'hFFFF_FFFC : 32'h0000_2000;
    next_addr  = st[0] ? 32'hFFFF_FFFC : 32'h0000_2004;
    vect_addr  = st[0] ? 32'h0000_0F00 : 32'h8000_0400;
    hivec      = hv;
    vect_en    = ve;
  endtask

  // called at posedge+1 with the stimulus still applied
  task automatic expect_entry(input int k, input string tag);
    chk($sformatf("%s R13 take", tag), 32'(take), 32'd1);
    chk($sformatf("%s R2 mode", tag), 32'(bank_sel), 32'(exp_mode(k)));
    chk($sformatf("%s R3/R4/R5 status", tag), new_status, exp_status(k));
    chk($sformatf("%s R7 saved", tag), saved_status, (k == 0) ? 32'd0 : cur_status);
    chk($sformatf("%s R6 link", tag), link_addr, exp_link(k));
    chk($sformatf("%s R8/R9 pc", tag), target_pc, exp_pc(k));
  endtask

  task automatic expect_idle(input string tag);
    @(posedge clk); #1;
    chk(tag, 32'(take), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    clear_in();
    set_ctx(0, 1'b1, 1'b0);
    ev_undef = 1; irq_req = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 take in reset", 32'(take), 32'd0);
    chk("R1 status in reset", new_status, 32'd0);
    chk("R1 saved in reset", saved_status, 32'd0);
    chk("R1 sel in reset", 32'(bank_sel), 32'd0);
    chk("R1 link in reset", link_addr, 32'd0);
    chk("R1 pc in reset", target_pc, 32'd0);
    @(negedge clk);
    clear_in();
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 take after release", 32'(take), 32'd0);
    chk("R1 pc after release", target_pc, 32'd0);
  endtask

  task automatic t_all_kinds();
    for (int st = 0; st < 2; st++)
      for (int hv = 0; hv < 2; hv++)
        for (int ve = 0; ve < 2; ve++)
          for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            clear_in();
            set_ctx(st, hv[0], ve[0]);
            drive_kind(k);
            @(posedge clk); #1;
            expect_entry(k, $sformatf("kind%0d st%0d hv%0d ve%0d", k, st, hv, ve));
          end
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_hold();
    logic [31:0] l_exp, p_exp;
    @(negedge clk);
    clear_in();
    set_ctx(1, 1'b1, 1'b0);
    drive_kind(4);
    l_exp = exp_link(4);
    p_exp = exp_pc(4);
    @(posedge clk); #1;
    expect_entry(4, "hold entry");
    @(negedge clk);
    clear_in();
    @(posedge clk); #1;
    chk("R13 take drops", 32'(take), 32'd0);
    chk("R13 link held", link_addr, l_exp);
    chk("R13 pc held", target_pc, p_exp);
  endtask

  task automatic t_masks();
    @(negedge clk); clear_in(); set_ctx(0, 1'b0, 1'b0);
    cur_status[7] = 1; irq_req = 1;
    expect_idle("R10 irq masked by bit 7");
    @(negedge clk); clear_in(); set_ctx(0, 1'b0, 1'b0);
    at_boundary = 0; irq_req = 1; fast_req = 1;
    expect_idle("R10 both off boundary");
    @(negedge clk); clear_in(); set_ctx(0, 1'b0, 1'b0);
    cur_status[6] = 1; fast_req = 1;
    expect_idle("R10 fast masked by bit 6");
    @(negedge clk); clear_in(); set_ctx(0, 1'b0, 1'b0);
    cur_status[6] = 1; fast_req = 1; irq_req = 1;
    @(posedge clk); #1;
    expect_entry(5, "R10 fast masked, irq taken");
    @(negedge clk); clear_in(); set_ctx(1, 1'b1, 1'b0);
    cur_status[7] = 1; fast_req = 1; irq_req = 1;
    @(posedge clk); #1;
    expect_entry(6, "R10 irq masked, fast taken");
    @(negedge clk); clear_in();
  endtask

  task automatic t_pabort();
    @(negedge clk); clear_in(); set_ctx(0, 1'b0, 1'b0);
    exec_valid = 0; ev_pabort = 1;
    expect_idle("R11 flushed fetch abort");
    @(negedge clk); clear_in(); set_ctx(0, 1'b1, 1'b0);
    exec_valid = 1; ev_pabort = 1;
    @(posedge clk); #1;
    expect_entry(3, "R11 executed fetch abort");
    @(negedge clk); clear_in();
  endtask

  task automatic t_priority();
    int order[7] = '{0, 4, 6, 5, 3, 1, 2};
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      clear_in();
      set_ctx(i % 2, i[1], 1'b0);
      for (int j = i; j < 7; j++) drive_kind(order[j]);
      @(posedge clk); #1;
      expect_entry(order[i], $sformatf("R12 priority level %0d", i));
    end
    @(negedge clk); clear_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_all_kinds();
    t_hold();
    t_masks();
    t_pabort();
    t_priority();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule